// File: doc/BRIEF.md
# I2C Bus Fault Classifier

A passive observer placed next to an I2C master engine. It watches the open-drain clock and data wires, and the master's own intentions: whether the master releases SDA, whether it releases SCL, and when it wants to start a transfer. The engine also gives per-bit phase strobes that say whether the current bit is an acknowledge slot, whether the current byte is the address byte, and whether the transfer reads. From these inputs the block sorts bus trouble into five fault classes. It drives no bus signal, performs no recovery and does no retries.

Both wires pass through a synchroniser. Every bus bit is judged at the rising edge of the synchronised clock. Each fault class has a sticky flag. A separate one-hot code field holds only the first fault seen since the last clear. A clear pulse empties both. A start request that meets a non-idle bus is refused, and the refusal is also logged as a fault. When arbitration is lost, an abandon pulse tells the engine to stop driving. A clock held low by another device is timed in prescaled ticks against a programmable 16-bit limit.

Top module: `i2c_fault_watch`

## Requirements
- R1: After reset, `err_flags`, `err_code`, `start_ok`, `start_refused` and `abort` are all zero.
- R2: Each raw wire passes through two flip-flops before it is used. A fault caused by a clock rise on `scl_in` appears on `err_flags` at the third rising `clk` edge after the raw rise, and not before.
- R3: If SDA reads high at a clock rise while `bit_ack`=1 and `byte_addr`=1, the block sets address-NACK flag bit 1 (code 5'b00010).
- R4: If SDA reads high at a clock rise while `bit_ack`=1, `byte_addr`=0 and `xfer_read`=0, the block sets write-data-NACK flag bit 2 (code 5'b00100). A low SDA in the same slot raises no fault.
- R5: During a read (`xfer_read`=1, `byte_addr`=0), slave-driven data bits of any value raise no fault, and neither does the master's own high (NACK) in the acknowledge slot.
- R6: The master owns SDA on address bits, on write data bits and on the acknowledge slot of a read. If SDA reads low at a clock rise on such a bit while `mst_sda_rel`=1, the block sets arbitration flag bit 3 (code 5'b01000) and pulses `abort` for one cycle.
- R7: A `start_req` cycle in which the synchronised SCL or SDA is low sets bus-busy flag bit 0 (code 5'b00001) and pulses `start_refused` one cycle later. With both wires high, it pulses `start_ok` instead.
- R8: While `mst_scl_rel`=1 and the synchronised SCL is low, a counter advances once per `TICK_DIV` clocks. When it reaches `stretch_limit`, the block sets timeout flag bit 4 (code 5'b10000). Any clock rise restarts the count, and a limit of 0 disables the check.
- R9: Flags stay set until cleared. `err_code` is one-hot and keeps the first fault latched after a clear, even when later faults of other classes set their flags.
- R10: A `clr` cycle zeroes `err_flags` and `err_code` one cycle later. A fault detected in the same cycle as `clr` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL wire level |
| sda_in | input | 1 | Raw SDA wire level |
| mst_scl_rel | input | 1 | Master is releasing SCL (not driving it low) |
| mst_sda_rel | input | 1 | Master is releasing SDA (intends high) |
| start_req | input | 1 | Master asks to begin a transfer (one-cycle pulse) |
| bit_ack | input | 1 | Current bit is the acknowledge slot |
| byte_addr | input | 1 | Current byte is the address byte |
| xfer_read | input | 1 | Transfer direction is read |
| clr | input | 1 | Clear all flags and the code |
| stretch_limit | input | 16 | Timeout limit in prescaled ticks; 0 disables |
| err_flags | output | 5 | Sticky fault flags, one bit per class |
| err_code | output | 5 | One-hot code of the first fault since clear |
| start_ok | output | 1 | Start request accepted (pulse) |
| start_refused | output | 1 | Start request refused, bus not idle (pulse) |
| abort | output | 1 | Arbitration lost, abandon the transfer (pulse) |

## Verification
The bench runs several transfer shapes through the classifier. A write whose bytes are all acknowledged must stay clean. An address byte left unacknowledged must raise the address class and nothing else. A data byte left unacknowledged must then set its own flag while the code still shows the address fault. A read with low slave data bits and a master NACK must stay clean, which shows that SDA ownership follows the phase strobes. An address bit pulled low by a rival must be flagged as lost arbitration. Start requests are made with SDA held low and then with an idle bus, to separate refusal from acceptance. Clock holds shorter than the limit, longer than it, and with a zero limit separate a real timeout from a long stretch and from the disabled case.

// File: rtl/i2c_fault_pkg.sv
package i2c_fault_pkg;
   localparam int NUM_FAULTS    = 5;
   localparam int FI_BUSY       = 0;
   localparam int FI_ADDR_NACK  = 1;
   localparam int FI_WDATA_NACK = 2;
   localparam int FI_ARB        = 3;
   localparam int FI_STRETCH    = 4;
   typedef logic [NUM_FAULTS-1:0] fault_vec_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE}};
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_tick_div.sv
module i2c_tick_div #(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit IS_POW2 = ((DIV & (DIV - 1)) == 0);

   if (DIV < 2) begin : g_bad_div
      $error("i2c_tick_div: DIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   if (IS_POW2) begin : g_pow2
      // counter wraps by itself; tick on all-ones
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt <= '0;
         else        cnt <= cnt + CW'(1);
      end
      assign tick = &cnt;
   end else begin : g_modulo
      assign tick = (cnt == CW'(DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cnt <= '0;
         else if (tick) cnt <= '0;
         else           cnt <= cnt + CW'(1);
      end
   end

   // R8: prescaled tick is a single-cycle strobe
   p_tick_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/i2c_stretch_timer.sv
module i2c_stretch_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         stretched,
   input  logic [W-1:0] limit,
   output logic         expired
);
   if (W < 1) begin : g_bad_w
      $error("i2c_stretch_timer: W must be positive");
   end

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt;
   logic         last_step;

   assign last_step = (limit != '0) && (cnt == limit - ONE);
   assign expired   = stretched & tick & last_step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt <= '0;
      else if (!stretched)               cnt <= '0;
      else if (tick && (cnt < limit))    cnt <= cnt + ONE;
   end

   // R8: any release of the hold (including a clock rise) restarts the count
   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !stretched |=> (cnt == '0));
endmodule

// File: rtl/i2c_fault_watch.sv
module i2c_fault_watch
   import i2c_fault_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int TICK_DIV    = 8,
   parameter int LIMIT_W     = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_in,
   input  logic                  sda_in,
   input  logic                  mst_scl_rel,
   input  logic                  mst_sda_rel,
   input  logic                  start_req,
   input  logic                  bit_ack,
   input  logic                  byte_addr,
   input  logic                  xfer_read,
   input  logic                  clr,
   input  logic [LIMIT_W-1:0]    stretch_limit,
   output logic [NUM_FAULTS-1:0] err_flags,
   output logic [NUM_FAULTS-1:0] err_code,
   output logic                  start_ok,
   output logic                  start_refused,
   output logic                  abort
);
   localparam fault_vec_t ONE_V = fault_vec_t'(1);

   logic       scl_s, sda_s, scl_d;
   logic       scl_rise, tick, stretched, tmo_ev;
   logic       master_owns, bus_idle;
   fault_vec_t ev, first_ev;

   i2c_line_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .din(scl_in), .dout(scl_s));
   i2c_line_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .din(sda_in), .dout(sda_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_d <= 1'b1;
      else        scl_d <= scl_s;
   end
   assign scl_rise = scl_s & ~scl_d;

   i2c_tick_div #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   assign stretched = mst_scl_rel & ~scl_s;

   i2c_stretch_timer #(.W(LIMIT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .stretched(stretched),
      .limit(stretch_limit), .expired(tmo_ev));

   // SDA owner per bit: master on address/write-data bits and on read ack slot
   assign master_owns = bit_ack ? (~byte_addr & xfer_read) : (byte_addr | ~xfer_read);
   assign bus_idle    = scl_s & sda_s;

   always_comb begin
      ev                = '0;
      ev[FI_BUSY]       = start_req & ~bus_idle;
      ev[FI_ADDR_NACK]  = scl_rise & bit_ack & byte_addr & sda_s;
      ev[FI_WDATA_NACK] = scl_rise & bit_ack & ~byte_addr & ~xfer_read & sda_s;
      ev[FI_ARB]        = scl_rise & master_owns & mst_sda_rel & ~sda_s;
      ev[FI_STRETCH]    = tmo_ev;
   end

   // isolate lowest-index fault when several coincide
   assign first_ev = ev & (~ev + ONE_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_flags     <= '0;
         err_code      <= '0;
         start_ok      <= 1'b0;
         start_refused <= 1'b0;
         abort         <= 1'b0;
      end else begin
         if (clr) begin
            err_flags <= '0;
            err_code  <= '0;
         end else begin
            err_flags <= err_flags | ev;
            if (err_code == '0) err_code <= first_ev;
         end
         start_ok      <= start_req & bus_idle;
         start_refused <= ev[FI_BUSY];
         abort         <= ev[FI_ARB];
      end
   end

   p_code_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(err_code));
   p_code_in_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code & ~err_flags) == '0);
   p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code != '0 && !clr) |=> $stable(err_code));
   p_flags_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));
   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (err_flags == '0 && err_code == '0));
   p_start_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_ok && start_refused));
   p_refuse_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_refused && !$past(clr)) |-> err_flags[FI_BUSY]);
   p_abort_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && !$past(clr)) |-> err_flags[FI_ARB]);
endmodule

// File: tb/i2c_fault_watch_bench.sv
module i2c_fault_watch_bench;
   localparam int DIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_in = 1'b1, sda_in = 1'b1;
   logic        mst_scl_rel = 1'b1, mst_sda_rel = 1'b1;
   logic        start_req = 1'b0, bit_ack = 1'b0, byte_addr = 1'b0, xfer_read = 1'b0;
   logic        clr = 1'b0;
   logic [15:0] stretch_limit = 16'd0;
   logic [4:0]  err_flags, err_code;
   logic        start_ok, start_refused, abort;

   always #10 clk = ~clk;

   i2c_fault_watch #(.TICK_DIV(DIV)) u_i2c_fault_watch (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .mst_scl_rel(mst_scl_rel), .mst_sda_rel(mst_sda_rel), .start_req(start_req),
      .bit_ack(bit_ack), .byte_addr(byte_addr), .xfer_read(xfer_read), .clr(clr),
      .stretch_limit(stretch_limit), .err_flags(err_flags), .err_code(err_code),
      .start_ok(start_ok), .start_refused(start_refused), .abort(abort));

   int checks = 0, failures = 0, cyc = 0;
   bit done = 0;

   task automatic chk(input bit good, input string what, input int act, input int exp);
      checks++;
      if (!good) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", what, act, exp);
      end
   endtask

   // reference model: wire history, tick phase, hold length, outputs
   bit        h_scl[$], h_sda[$];
   bit        m_scl_prev;
   int        m_phase, m_hold;
   logic [4:0] m_flags, m_code;
   bit        m_ok, m_ref, m_abort, m_valid;

   always @(posedge clk) begin
      if (!rst_n) begin
         h_scl = '{1, 1}; h_sda = '{1, 1};
         m_scl_prev = 1; m_phase = 0; m_hold = 0;
         m_flags = 0; m_code = 0; m_ok = 0; m_ref = 0; m_abort = 0; m_valid = 0;
      end else begin
         bit scl_v, sda_v, rise, tick, held, owner;
         logic [4:0] ev;
         scl_v = h_scl[0]; sda_v = h_sda[0];
         rise  = scl_v && !m_scl_prev;
         tick  = (m_phase == DIV - 1);
         held  = mst_scl_rel && !scl_v;
         owner = bit_ack ? (!byte_addr && xfer_read) : (byte_addr || !xfer_read);
         ev = 0;
         if (start_req && !(scl_v && sda_v)) ev[0] = 1;
         if (rise && bit_ack && byte_addr && sda_v) ev[1] = 1;
         if (rise && bit_ack && !byte_addr && !xfer_read && sda_v) ev[2] = 1;
         if (rise && owner && mst_sda_rel && !sda_v) ev[3] = 1;
         if (held && tick && stretch_limit != 0 && m_hold == int'(stretch_limit) - 1) ev[4] = 1;
         if (clr) begin m_flags = 0; m_code = 0; end
         else begin
            m_flags |= ev;
            if (m_code == 0)
               for (int i = 4; i >= 0; i--) if (ev[i]) m_code = 5'(1 << i);
         end
         m_ok = start_req && scl_v && sda_v;
         m_ref = ev[0];
         m_abort = ev[3];
         if (!held) m_hold = 0;
         else if (tick && m_hold < int'(stretch_limit)) m_hold++;
         m_phase = tick ? 0 : m_phase + 1;
         m_scl_prev = scl_v;
         void'(h_scl.pop_front()); h_scl.push_back(scl_in);
         void'(h_sda.pop_front()); h_sda.push_back(sda_in);
         m_valid = 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && m_valid && !done) begin
         chk(err_flags == m_flags, "R9 model flags", err_flags, m_flags);
         chk(err_code == m_code, "R9 model code", err_code, m_code);
         chk(start_ok == m_ok && start_refused == m_ref, "R7 model start",
             {start_ok, start_refused}, {m_ok, m_ref});
         chk(abort == m_abort, "R6 model abort", abort, m_abort);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog act=%0d exp=0", cyc);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic bus_bit(input bit m_rel, input bit slv, input bit ack, input bit adr, input bit rd);
      @(negedge clk);
      scl_in = 0; mst_scl_rel = 0;
      bit_ack = ack; byte_addr = adr; xfer_read = rd;
      mst_sda_rel = m_rel; sda_in = m_rel & slv;
      repeat (4) @(negedge clk);
      scl_in = 1; mst_scl_rel = 1;
      repeat (6) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] v, input bit adr, input bit rd);
      for (int i = 7; i >= 0; i--) bus_bit(v[i], 1'b1, 1'b0, adr, rd);
   endtask

   task automatic recv_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) bus_bit(1'b1, v[i], 1'b0, 1'b0, 1'b1);
   endtask

   task automatic go_idle();
      @(negedge clk);
      scl_in = 1; sda_in = 1; mst_scl_rel = 1; mst_sda_rel = 1;
      bit_ack = 0; byte_addr = 0; xfer_read = 0;
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr = 1;
      @(negedge clk); clr = 0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(err_flags == 0 && err_code == 0, "R1 reset flags/code", {err_flags, err_code}, 0);
      chk({start_ok, start_refused, abort} == 0, "R1 reset pulses", {start_ok, start_refused, abort}, 0);

      // clean write: address acked, data acked
      send_byte(8'hA4, 1, 0);
      bus_bit(1, 0, 1, 1, 0);
      send_byte(8'h3C, 0, 0);
      bus_bit(1, 0, 1, 0, 0);
      go_idle();
      chk(err_flags == 0, "R4 acked write clean", err_flags, 0);

      // address NACK with explicit latency check
      send_byte(8'h50, 1, 0);
      @(negedge clk);
      scl_in = 0; mst_scl_rel = 0; bit_ack = 1; byte_addr = 1; mst_sda_rel = 1; sda_in = 1;
      repeat (4) @(negedge clk);
      scl_in = 1; mst_scl_rel = 1;
      repeat (2) @(negedge clk);
      chk(err_flags[1] == 0, "R2 no flag before sync latency", err_flags[1], 0);
      @(negedge clk);
      chk(err_flags[1] == 1, "R2 flag at third edge", err_flags[1], 1);
      chk(err_code == 5'b00010, "R3 address NACK code", err_code, 5'b00010);
      repeat (3) @(negedge clk);

      // data NACK afterwards: flag set, code kept
      send_byte(8'h11, 0, 0);
      bus_bit(1, 1, 1, 0, 0);
      go_idle();
      chk(err_flags == 5'b00110, "R4 write data NACK flag", err_flags, 5'b00110);
      chk(err_code == 5'b00010, "R9 first code held", err_code, 5'b00010);

      pulse_clr();
      chk(err_flags == 0 && err_code == 0, "R10 clear", {err_flags, err_code}, 0);

      // read with master NACK at end
      send_byte(8'hA5, 1, 1);
      bus_bit(1, 0, 1, 1, 1);
      recv_byte(8'h5A);
      bus_bit(1, 1, 1, 0, 1);
      go_idle();
      chk(err_flags == 0, "R5 read with master NACK clean", err_flags, 0);

      // arbitration loss on an address bit
      bus_bit(1, 0, 0, 1, 0);
      go_idle();
      chk(err_flags == 5'b01000, "R6 arbitration flag", err_flags, 5'b01000);
      chk(err_code == 5'b01000, "R6 arbitration code", err_code, 5'b01000);
      pulse_clr();

      // bus busy: SDA held low at start request
      @(negedge clk); sda_in = 0;
      repeat (4) @(negedge clk);
      start_req = 1;
      @(negedge clk); start_req = 0;
      chk(start_refused == 1 && start_ok == 0, "R7 refused on busy", {start_ok, start_refused}, 1);
      chk(err_code == 5'b00001, "R7 busy code", err_code, 5'b00001);
      @(negedge clk); sda_in = 1;
      repeat (4) @(negedge clk);
      start_req = 1;
      @(negedge clk); start_req = 0;
      chk(start_ok == 1 && start_refused == 0, "R7 accepted when idle", {start_ok, start_refused}, 2);
      pulse_clr();

      // clr coinciding with a fault drops the fault
      @(negedge clk); sda_in = 0;
      repeat (4) @(negedge clk);
      start_req = 1; clr = 1;
      @(negedge clk); start_req = 0; clr = 0;
      chk(err_flags == 0, "R10 clear wins over same-cycle fault", err_flags, 0);
      sda_in = 1;
      repeat (4) @(negedge clk);

      // stretch shorter than limit
      stretch_limit = 16'd20;
      @(negedge clk); scl_in = 0; mst_scl_rel = 1;
      repeat (30) @(negedge clk);
      scl_in = 1;
      repeat (5) @(negedge clk);
      chk(err_flags == 0, "R8 short stretch no timeout", err_flags, 0);

      // stretch longer than limit
      stretch_limit = 16'd5;
      @(negedge clk); scl_in = 0;
      repeat (40) @(negedge clk);
      scl_in = 1;
      repeat (5) @(negedge clk);
      chk(err_flags == 5'b10000, "R8 timeout flag", err_flags, 5'b10000);
      chk(err_code == 5'b10000, "R8 timeout code", err_code, 5'b10000);
      pulse_clr();

      // limit zero disables
      stretch_limit = 16'd0;
      @(negedge clk); scl_in = 0;
      repeat (60) @(negedge clk);
      scl_in = 1;
      repeat (5) @(negedge clk);
      chk(err_flags == 0, "R8 zero limit disabled", err_flags, 0);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule